// File: doc/BRIEF.md
# PCI Function State Controller

This block keeps the lifecycle state of a single virtualised PCI function. Software or a hot-plug agent issues one command per cycle: plug, unplug, configure, deconfigure, enable, disable, block, error, permanent error, or a modify-controls reset. The block checks each command against the current state. It either moves to a new state or refuses the command and leaves everything unchanged.

Four states (disabled, enabled, blocked, error) and a fifth, permanent error, together form a "configured" group. Configure enters this group and deconfigure leaves it. Inside the group, each command has its own exits.

Alongside the state, the block keeps a 32-bit function-handle word. The word carries an enable flag, an instance counter, a type code and the function index. Lifecycle transitions also raise a one-cycle hot-plug event with a fixed 16-bit code. All outputs are registered and change one cycle after the command is sampled.

Top module: `pci_fn_lifecycle`

## Requirements
- R1: A synchronous reset puts the block in reserved with `fn_handle` = 0, `configured` = 0, `reject` = 0 and `evt_valid` = 0.
- R2: `fn_state` encodes reserved=0, standby=1, disabled=2, enabled=3, blocked=4, error=5, permanent error=6. No other value ever appears.
- R3: Plug (code 0) in reserved moves to standby and raises event 0x0302. It loads the handle with bits 23:16 = `TYPE_CODE`, bits 15:0 = `FN_INDEX` and bit 31 = 0, and it keeps the instance field (bits 30:24). Unplug (code 1) in standby moves to reserved, raises event 0x0308 and leaves the handle unchanged.
- R4: Configure (code 2) in standby moves to disabled and raises event 0x0301. `configured` is 1 exactly in states 2 through 6.
- R5: Enable (code 4) in disabled moves to enabled. It sets handle bit 31 and adds one, modulo 128, to the instance field in bits 30:24. Disable (code 5) in enabled moves to disabled and clears bit 31. Neither raises an event.
- R6: From enabled, block (code 6) moves to blocked and error (code 7) moves to error. Modify-controls (code 9) in blocked or error returns to enabled with bit 31 set and the instance unchanged.
- R7: Permanent error (code 8) is accepted in enabled, blocked or error. Once in permanent error, only deconfigure moves the block, and it moves it to standby.
- R8: Deconfigure (code 3) in any state from 2 to 6 moves to standby, raises event 0x0304 and clears handle bit 31.
- R9: Unplug while in a state from 2 to 6 is accepted without a state change and raises event 0x0303.
- R10: Any other state/command pair, including codes 10 to 15, leaves the state and handle unchanged. It raises `reject` for exactly one cycle and raises no event.
- R11: Outputs reflect a command on the cycle after it is sampled. A cycle with `cmd_valid` low holds the state and handle, and brings `reject` and `evt_valid` low with `evt_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 4 | Command code (see R3 to R10) |
| fn_state | output | 3 | Current lifecycle state |
| fn_handle | output | 32 | Function-handle word |
| configured | output | 1 | State is in the configured group |
| reject | output | 1 | Previous command was illegal |
| evt_valid | output | 1 | Hot-plug event strobe |
| evt_code | output | 16 | Hot-plug event code, 0 when no event |

## Verification
The bench builds the block with `TYPE_CODE` = 0x01 and `FN_INDEX` = 0x00A5. These values make the type and index fields distinct from zero and from each other in every handle the bench compares. A long run of enable/disable pairs carries the 7-bit instance field past 127, so the wrap to zero is observed at the ports. A second plug after an unplug shows that the instance survives the reload of the handle.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

    typedef enum logic [2:0] {
        FS_RESERVED   = 3'd0,
        FS_STANDBY    = 3'd1,
        FS_DISABLED   = 3'd2,
        FS_ENABLED    = 3'd3,
        FS_BLOCKED    = 3'd4,
        FS_ERROR      = 3'd5,
        FS_PERM_ERROR = 3'd6
    } fn_state_e;

    localparam logic [3:0] CMD_PLUG      = 4'd0;
    localparam logic [3:0] CMD_UNPLUG    = 4'd1;
    localparam logic [3:0] CMD_CONFIGURE = 4'd2;
    localparam logic [3:0] CMD_DECONFIG  = 4'd3;
    localparam logic [3:0] CMD_ENABLE    = 4'd4;
    localparam logic [3:0] CMD_DISABLE   = 4'd5;
    localparam logic [3:0] CMD_BLOCK     = 4'd6;
    localparam logic [3:0] CMD_ERROR     = 4'd7;
    localparam logic [3:0] CMD_PERM      = 4'd8;
    localparam logic [3:0] CMD_MODIFY    = 4'd9;

    localparam logic [15:0] EVT_TO_CONFIGURED  = 16'h0301;
    localparam logic [15:0] EVT_RSV_TO_STANDBY = 16'h0302;
    localparam logic [15:0] EVT_DECONF_REQ     = 16'h0303;
    localparam logic [15:0] EVT_CFG_TO_STANDBY = 16'h0304;
    localparam logic [15:0] EVT_STANDBY_TO_RSV = 16'h0308;

    function automatic logic in_cfg_group(input fn_state_e s);
        return (s >= FS_DISABLED) && (s <= FS_PERM_ERROR);
    endfunction

endpackage

// File: rtl/pfl_decode.sv
module pfl_decode
    import pfl_pkg::*;
(
    input  fn_state_e   cur_state,
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_code,
    output fn_state_e   nxt_state,
    output logic        cmd_reject,
    output logic        evt_raise,
    output logic [15:0] evt_value,
    output logic        load_id,
    output logic        bump_inst,
    output logic        set_en,
    output logic        clr_en
);
    logic ok;

    always_comb begin
        nxt_state = cur_state;
        ok        = 1'b0;
        evt_raise = 1'b0;
        evt_value = '0;
        load_id   = 1'b0;
        bump_inst = 1'b0;
        set_en    = 1'b0;
        clr_en    = 1'b0;
        if (cmd_valid) begin
            case (cmd_code)
                CMD_PLUG: if (cur_state == FS_RESERVED) begin
                    nxt_state = FS_STANDBY; ok = 1'b1; load_id = 1'b1;
                    evt_raise = 1'b1; evt_value = EVT_RSV_TO_STANDBY;
                end
                CMD_UNPLUG: begin
                    if (cur_state == FS_STANDBY) begin
                        nxt_state = FS_RESERVED; ok = 1'b1;
                        evt_raise = 1'b1; evt_value = EVT_STANDBY_TO_RSV;
                    end else if (in_cfg_group(cur_state)) begin
                        ok = 1'b1;
                        evt_raise = 1'b1; evt_value = EVT_DECONF_REQ;
                    end
                end
                CMD_CONFIGURE: if (cur_state == FS_STANDBY) begin
                    nxt_state = FS_DISABLED; ok = 1'b1;
                    evt_raise = 1'b1; evt_value = EVT_TO_CONFIGURED;
                end
                CMD_DECONFIG: if (in_cfg_group(cur_state)) begin
                    nxt_state = FS_STANDBY; ok = 1'b1; clr_en = 1'b1;
                    evt_raise = 1'b1; evt_value = EVT_CFG_TO_STANDBY;
                end
                CMD_ENABLE: if (cur_state == FS_DISABLED) begin
                    nxt_state = FS_ENABLED; ok = 1'b1;
                    set_en = 1'b1; bump_inst = 1'b1;
                end
                CMD_DISABLE: if (cur_state == FS_ENABLED) begin
                    nxt_state = FS_DISABLED; ok = 1'b1; clr_en = 1'b1;
                end
                CMD_BLOCK: if (cur_state == FS_ENABLED) begin
                    nxt_state = FS_BLOCKED; ok = 1'b1;
                end
                CMD_ERROR: if (cur_state == FS_ENABLED) begin
                    nxt_state = FS_ERROR; ok = 1'b1;
                end
                CMD_PERM: if (cur_state == FS_ENABLED || cur_state == FS_BLOCKED ||
                              cur_state == FS_ERROR) begin
                    nxt_state = FS_PERM_ERROR; ok = 1'b1;
                end
                CMD_MODIFY: if (cur_state == FS_BLOCKED || cur_state == FS_ERROR) begin
                    nxt_state = FS_ENABLED; ok = 1'b1; set_en = 1'b1;
                end
                default: ok = 1'b0;
            endcase
        end
        cmd_reject = cmd_valid && !ok;
    end

endmodule

// File: rtl/pfl_handle.sv
module pfl_handle #(
    parameter int          INST_W    = 7,
    parameter int          TYPE_W    = 8,
    parameter int          IDX_W     = 16,
    parameter logic [TYPE_W-1:0] TYPE_CODE = 8'h02,
    parameter logic [IDX_W-1:0]  FN_INDEX  = 16'h0000,
    localparam int         HANDLE_W  = 1 + INST_W + TYPE_W + IDX_W
) (
    input  logic [HANDLE_W-1:0] cur_handle,
    input  logic                load_id,
    input  logic                bump_inst,
    input  logic                set_en,
    input  logic                clr_en,
    output logic [HANDLE_W-1:0] nxt_handle
);
    localparam int EN_POS   = HANDLE_W - 1;
    localparam int INST_LSB = TYPE_W + IDX_W;
    localparam int TYPE_LSB = IDX_W;

    logic [INST_W-1:0] inst_q;

    always_comb begin
        nxt_handle = cur_handle;
        inst_q     = cur_handle[INST_LSB +: INST_W];
        if (load_id) begin
            nxt_handle[TYPE_LSB +: TYPE_W] = TYPE_CODE;
            nxt_handle[0 +: IDX_W]         = FN_INDEX;
            nxt_handle[EN_POS]             = 1'b0;
        end
        if (bump_inst) begin
            nxt_handle[INST_LSB +: INST_W] = inst_q + 1'b1;
        end
        if (set_en) begin
            nxt_handle[EN_POS] = 1'b1;
        end else if (clr_en) begin
            nxt_handle[EN_POS] = 1'b0;
        end
    end

endmodule

// File: rtl/pci_fn_lifecycle.sv
module pci_fn_lifecycle
    import pfl_pkg::*;
#(
    parameter int                INST_W    = 7,
    parameter int                TYPE_W    = 8,
    parameter int                IDX_W     = 16,
    parameter logic [TYPE_W-1:0] TYPE_CODE = 8'h02,
    parameter logic [IDX_W-1:0]  FN_INDEX  = 16'h0000,
    localparam int               HANDLE_W  = 1 + INST_W + TYPE_W + IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_code,
    output logic [2:0]          fn_state,
    output logic [HANDLE_W-1:0] fn_handle,
    output logic                configured,
    output logic                reject,
    output logic                evt_valid,
    output logic [15:0]         evt_code
);
    typedef struct packed {
        fn_state_e           state;
        logic [HANDLE_W-1:0] handle;
        logic                reject;
        logic                evt_valid;
        logic [15:0]         evt_code;
    } regs_t;

    regs_t r_d, r_q;

    fn_state_e           dec_state;
    logic                dec_reject, dec_evt, dec_load, dec_bump, dec_set, dec_clr;
    logic [15:0]         dec_code;
    logic [HANDLE_W-1:0] hdl_next;

    pfl_decode u_decode (
        .cur_state  (r_q.state),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .nxt_state  (dec_state),
        .cmd_reject (dec_reject),
        .evt_raise  (dec_evt),
        .evt_value  (dec_code),
        .load_id    (dec_load),
        .bump_inst  (dec_bump),
        .set_en     (dec_set),
        .clr_en     (dec_clr)
    );

    pfl_handle #(
        .INST_W    (INST_W),
        .TYPE_W    (TYPE_W),
        .IDX_W     (IDX_W),
        .TYPE_CODE (TYPE_CODE),
        .FN_INDEX  (FN_INDEX)
    ) u_handle (
        .cur_handle (r_q.handle),
        .load_id    (dec_load),
        .bump_inst  (dec_bump),
        .set_en     (dec_set),
        .clr_en     (dec_clr),
        .nxt_handle (hdl_next)
    );

    always_comb begin
        r_d           = r_q;
        r_d.state     = dec_state;
        r_d.handle    = hdl_next;
        r_d.reject    = dec_reject;
        r_d.evt_valid = dec_evt;
        r_d.evt_code  = dec_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fn_state   = r_q.state;
    assign fn_handle  = r_q.handle;
    assign configured = in_cfg_group(r_q.state);
    assign reject     = r_q.reject;
    assign evt_valid  = r_q.evt_valid;
    assign evt_code   = r_q.evt_code;

endmodule

// File: rtl/pfl_checker.sv
module pfl_checker #(
    parameter int HANDLE_W = 32,
    parameter int INST_W   = 7
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          fn_state,
    input logic [HANDLE_W-1:0] fn_handle,
    input logic                configured,
    input logic                reject,
    input logic                evt_valid,
    input logic [15:0]         evt_code
);
    localparam int EN_POS   = HANDLE_W - 1;
    localparam int INST_LSB = HANDLE_W - 1 - INST_W;

    assert_legal_state_R2: assert property (@(posedge clk) disable iff (rst)
        fn_state <= 3'd6);

    assert_standby_evt_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_code == 16'h0302) |-> fn_state == 3'd1);

    assert_enabled_bit_R5: assert property (@(posedge clk) disable iff (rst)
        fn_state == 3'd3 |-> fn_handle[EN_POS]);

    assert_inst_moves_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(fn_handle[INST_LSB +: INST_W]) |-> fn_state == 3'd3);

    assert_perm_exit_R7: assert property (@(posedge clk) disable iff (rst)
        fn_state == 3'd6 |=> (fn_state == 3'd6 || fn_state == 3'd1));

    assert_enbit_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        fn_handle[EN_POS] |-> configured);

    assert_reject_hold_R10: assert property (@(posedge clk) disable iff (rst)
        reject |-> ($stable(fn_state) && $stable(fn_handle)));

    assert_reject_noevt_R10: assert property (@(posedge clk) disable iff (rst)
        !(reject && evt_valid));

endmodule

bind pci_fn_lifecycle pfl_checker #(
    .HANDLE_W (HANDLE_W),
    .INST_W   (INST_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fn_state   (fn_state),
    .fn_handle  (fn_handle),
    .configured (configured),
    .reject     (reject),
    .evt_valid  (evt_valid),
    .evt_code   (evt_code)
);

// File: tb/pci_fn_lifecycle_tb.sv
module pci_fn_lifecycle_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = 4'd0;
    logic [2:0]  fn_state;
    logic [31:0] fn_handle;
    logic        configured, reject, evt_valid;
    logic [15:0] evt_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pci_fn_lifecycle #(
        .TYPE_CODE (8'h01),
        .FN_INDEX  (16'h00A5)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .fn_state   (fn_state),
        .fn_handle  (fn_handle),
        .configured (configured),
        .reject     (reject),
        .evt_valid  (evt_valid),
        .evt_code   (evt_code)
    );

    // {cmd, state, reject, evt_valid, evt_code, handle}
    localparam int NV = 29;
    localparam logic [56:0] VEC [NV] = '{
        {4'd2, 3'd0, 1'b1, 1'b0, 16'h0000, 32'h00000000}, // R10 configure in reserved
        {4'd0, 3'd1, 1'b0, 1'b1, 16'h0302, 32'h000100A5}, // R3 plug
        {4'd4, 3'd1, 1'b1, 1'b0, 16'h0000, 32'h000100A5}, // R10 enable in standby
        {4'd2, 3'd2, 1'b0, 1'b1, 16'h0301, 32'h000100A5}, // R4 configure
        {4'd4, 3'd3, 1'b0, 1'b0, 16'h0000, 32'h810100A5}, // R5 enable
        {4'd6, 3'd4, 1'b0, 1'b0, 16'h0000, 32'h810100A5}, // R6 block
        {4'd9, 3'd3, 1'b0, 1'b0, 16'h0000, 32'h810100A5}, // R6 modify from blocked
        {4'd7, 3'd5, 1'b0, 1'b0, 16'h0000, 32'h810100A5}, // R6 error
        {4'd4, 3'd5, 1'b1, 1'b0, 16'h0000, 32'h810100A5}, // R10 enable in error
        {4'd9, 3'd3, 1'b0, 1'b0, 16'h0000, 32'h810100A5}, // R6 modify from error
        {4'd1, 3'd3, 1'b0, 1'b1, 16'h0303, 32'h810100A5}, // R9 unplug while configured
        {4'd5, 3'd2, 1'b0, 1'b0, 16'h0000, 32'h010100A5}, // R5 disable
        {4'd4, 3'd3, 1'b0, 1'b0, 16'h0000, 32'h820100A5}, // R5 second enable
        {4'd8, 3'd6, 1'b0, 1'b0, 16'h0000, 32'h820100A5}, // R7 perm from enabled
        {4'd9, 3'd6, 1'b1, 1'b0, 16'h0000, 32'h820100A5}, // R7 modify refused
        {4'd4, 3'd6, 1'b1, 1'b0, 16'h0000, 32'h820100A5}, // R7 enable refused
        {4'd3, 3'd1, 1'b0, 1'b1, 16'h0304, 32'h020100A5}, // R8 deconfigure from perm
        {4'd1, 3'd0, 1'b0, 1'b1, 16'h0308, 32'h020100A5}, // R3 unplug
        {4'd12,3'd0, 1'b1, 1'b0, 16'h0000, 32'h020100A5}, // R10 undefined code
        {4'd0, 3'd1, 1'b0, 1'b1, 16'h0302, 32'h020100A5}, // R3 replug keeps instance
        {4'd2, 3'd2, 1'b0, 1'b1, 16'h0301, 32'h020100A5}, // R4 configure
        {4'd3, 3'd1, 1'b0, 1'b1, 16'h0304, 32'h020100A5}, // R8 deconfigure from disabled
        {4'd2, 3'd2, 1'b0, 1'b1, 16'h0301, 32'h020100A5}, // R4 configure
        {4'd4, 3'd3, 1'b0, 1'b0, 16'h0000, 32'h830100A5}, // R5 enable
        {4'd6, 3'd4, 1'b0, 1'b0, 16'h0000, 32'h830100A5}, // R6 block
        {4'd5, 3'd4, 1'b1, 1'b0, 16'h0000, 32'h830100A5}, // R10 disable in blocked
        {4'd7, 3'd4, 1'b1, 1'b0, 16'h0000, 32'h830100A5}, // R10 error in blocked
        {4'd8, 3'd6, 1'b0, 1'b0, 16'h0000, 32'h830100A5}, // R7 perm from blocked
        {4'd3, 3'd1, 1'b0, 1'b1, 16'h0304, 32'h030100A5}  // R8 deconfigure
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic check_all(input string req, input logic [2:0] st, input logic rj,
                             input logic ev, input logic [15:0] cd, input logic [31:0] h);
        check({req, " state"},  64'(fn_state), 64'(st));
        check({req, " reject"}, 64'(reject), 64'(rj));
        check({req, " evt"},    64'(evt_valid), 64'(ev));
        check({req, " code"},   64'(evt_code), 64'(cd));
        check({req, " handle"}, 64'(fn_handle), 64'(h));
        check({req, " configured R4"}, 64'(configured),
              64'((st >= 3'd2) && (st <= 3'd6)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] inst;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_all("R1", 3'd0, 1'b0, 1'b0, 16'h0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][56:53]);
            check_all($sformatf("vec%0d R11", i), VEC[i][52:50], VEC[i][49],
                      VEC[i][48], VEC[i][47:32], VEC[i][31:0]);
        end

        // R11 idle cycle holds state and clears strobes
        @(negedge clk);
        check_all("R11 idle", 3'd1, 1'b0, 1'b0, 16'h0, 32'h030100A5);

        // R5 instance wrap across 128 enables
        issue(4'd2);
        inst = 7'd3;
        for (int k = 0; k < 130; k++) begin
            issue(4'd4);
            inst = inst + 7'd1;
            check("R5 wrap enable handle", 64'(fn_handle),
                  64'({1'b1, inst, 8'h01, 16'h00A5}));
            issue(4'd5);
            check("R5 wrap disable handle", 64'(fn_handle),
                  64'({1'b0, inst, 8'h01, 16'h00A5}));
        end
        check("R5 wrapped instance", 64'(inst), 64'(7'd5));

        // R1 reset from a configured state
        issue(4'd4);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 mid reset", 3'd0, 1'b0, 1'b0, 16'h0, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule